// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is a slave receiver for a stereo serial audio stream. Three input lines come from an external source: a bit clock, a word-select line and a data line. The block samples all three with the system clock `clk`. It finds the rising edges of the bit clock and splits the stream into left and right channel words. The left word travels while word-select is low and the right word while it is high.

A 3-bit code selects how a word sits inside its word-select half-period, which is called a slot. In I2S mode the word starts one bit after the word-select edge. In MSB-justified mode it starts on the edge itself. In the LSB-justified modes the word ends on the bit just before the next edge, with a fixed length of 16, 18 or 20 bits. Each channel is presented as a 20-bit sample aligned to the most significant bit, padded with zeros at the bottom. When a full left-then-right pair has arrived, both samples are updated together and a one-cycle valid pulse is issued.

A new format code takes effect only at the start of a frame. A frame starts where word-select falls into the left slot, so a code change in the middle of a frame never splits the two channels of that frame.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `left_o` and `right_o` are zero and `frame_valid_o` is low.
- R2: Format code 000 (I2S): the word MSB is the bit sampled on the second rising bit-clock edge after a word-select change. A word of W ≤ 20 bits is presented as word << (20−W). For W > 20 only the first 20 bits are kept. The bit on the first rising edge of the slot and all bits after the 21st rising edge are ignored.
- R3: Format code 100 (MSB-justified): the word MSB is the bit sampled on the first rising edge after a word-select change. Alignment and truncation are the same as in R2, and bits after the 20th of the slot are ignored.
- R4: Format codes 001, 010 and 011 (LSB-justified, N = 16, 18 or 20): the word is the last N bits sampled before the word-select change, presented as word << (20−N). Any earlier bits of the slot are ignored.
- R5: The slot with word-select low is the left channel and the slot with word-select high is the right channel. A frame is a left slot followed by a right slot. The frame completes on the first rising bit-clock edge after word-select returns low. `frame_valid_o` is then high for exactly one cycle, with both samples updated in that same cycle, and both samples hold until the next pulse.
- R6: The format code is sampled at the rising edge that starts a left slot. Changes to `fmt_i` at any other time do not affect the frame in progress.
- R7: The unused codes 101, 110 and 111 decode as I2S.
- R8: After reset, the slot in progress is incomplete and is discarded. No pulse is issued until a complete left slot and right slot have both been received.
- R9: Slots of any length up to MAX_SLOT bits are accepted. The slot length may change from one frame to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| bck_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ws_i | input | 1 | Word select: low = left, high = right |
| sdata_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 3 | Format code (see R2–R4, R7) |
| left_o | output | SAMPLE_W | Left sample, MSB-aligned |
| right_o | output | SAMPLE_W | Right sample, MSB-aligned |
| frame_valid_o | output | 1 | One-cycle pulse when a stereo pair is complete |

## Verification
The bench builds the receiver with its default parameters: 20-bit samples, slots of up to 32 bits and a two-stage input synchronizer. The bit clock runs at one eighth of the system clock. Frames with 24-bit and 32-bit slots follow each other back to back. This exercises words shorter than, equal to and longer than 20 bits, and ones placed in the unused bits of each slot show that those bits are discarded. The stream also includes a format code changed in the middle of a frame, an unused code, and a reset in the middle of the stream followed by a partial slot.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam logic [2:0] FMT_I2S   = 3'b000;
  localparam logic [2:0] FMT_LSB16 = 3'b001;
  localparam logic [2:0] FMT_LSB18 = 3'b010;
  localparam logic [2:0] FMT_LSB20 = 3'b011;
  localparam logic [2:0] FMT_MSBJ  = 3'b100;

  // Word length for the formats that are located from the trailing edge; 0 otherwise.
  function automatic int lsb_len(input logic [2:0] f);
    case (f)
      FMT_LSB16: return 16;
      FMT_LSB18: return 18;
      FMT_LSB20: return 20;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/sa_pin_sync.sv
module sa_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_i,
  input  logic ws_i,
  input  logic dat_i,
  output logic rise_o,
  output logic ws_o,
  output logic dat_o
);
  localparam int NPIN = 3;

  logic [STAGES-1:0][NPIN-1:0] pipe;
  logic                        bck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      bck_last <= 1'b0;
    end else begin
      pipe     <= {pipe[STAGES-2:0], {bck_i, ws_i, dat_i}};
      bck_last <= pipe[STAGES-1][2];
    end
  end

  assign rise_o = pipe[STAGES-1][2] & ~bck_last;
  assign ws_o   = pipe[STAGES-1][1];
  assign dat_o  = pipe[STAGES-1][0];

  // R5
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sa_slot_capture.sv
module sa_slot_capture import sa_pkg::*; #(
  parameter int SAMPLE_W = 20,
  parameter int MAX_SLOT = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_i,
  input  logic                ws_i,
  input  logic                dat_i,
  input  logic [2:0]          fmt_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                chan_o,
  output logic                word_vld_o
);
  localparam int CNT_W = $clog2(MAX_SLOT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_SLOT);

  logic                ws_prev, seen, boundary;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] sh, acc, acc_n, lsb_word;
  logic [2:0]          fmt_act, fmt_nxt;
  int                  pos, idx, n_act;

  always_comb begin
    boundary = rise_i && (ws_i != ws_prev);
    // A new code is taken only where a left slot begins.
    fmt_nxt  = (boundary && !ws_i) ? fmt_i : fmt_act;
    pos      = boundary ? 0 : int'(cnt) + 1;
    idx      = (fmt_nxt == FMT_MSBJ) ? pos : pos - 1;
    acc_n    = boundary ? '0 : acc;
    for (int b = 0; b < SAMPLE_W; b++) begin
      if (idx == SAMPLE_W - 1 - b) acc_n[b] = dat_i;
    end
    n_act    = lsb_len(fmt_act);
    lsb_word = sh << (SAMPLE_W - n_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev    <= 1'b0;
      seen       <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      acc        <= '0;
      fmt_act    <= FMT_I2S;
      word_o     <= '0;
      chan_o     <= 1'b0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (rise_i) begin
        ws_prev <= ws_i;
        sh      <= {sh[SAMPLE_W-2:0], dat_i};
        acc     <= acc_n;
        fmt_act <= fmt_nxt;
        if (boundary)            cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (boundary) begin
          seen <= 1'b1;
          if (seen) begin
            word_vld_o <= 1'b1;
            chan_o     <= ws_prev;
            word_o     <= (n_act != 0) ? lsb_word : acc;
          end
        end
      end
    end
  end

  // R5
  word_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> $past(rise_i));
  // R6
  fmt_at_left_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fmt_act) |-> ($past(rise_i) && !$past(ws_i)));
endmodule

// File: rtl/sa_frame_pair.sv
module sa_frame_pair #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                chan_i,
  input  logic                vld_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                frame_valid_o
);
  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold     <= '0;
      have_left     <= 1'b0;
      left_o        <= '0;
      right_o       <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      frame_valid_o <= 1'b0;
      if (vld_i) begin
        if (!chan_i) begin
          left_hold <= word_i;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o        <= left_hold;
          right_o       <= word_i;
          frame_valid_o <= 1'b1;
          have_left     <= 1'b0;
        end
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (left_o == '0 && right_o == '0 && !frame_valid_o));
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |=> !frame_valid_o);
  // R5
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_valid_o |-> ($stable(left_o) && $stable(right_o)));
  // R8
  right_closes_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> ($past(vld_i) && $past(chan_i)));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W    = 20,
  parameter int MAX_SLOT    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bck_i,
  input  logic                ws_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                frame_valid_o
);
  logic                rise, ws_s, dat_s, word_vld, word_chan;
  logic [SAMPLE_W-1:0] word;

  sa_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bck_i(bck_i), .ws_i(ws_i), .dat_i(sdata_i),
    .rise_o(rise), .ws_o(ws_s), .dat_o(dat_s)
  );

  sa_slot_capture #(.SAMPLE_W(SAMPLE_W), .MAX_SLOT(MAX_SLOT)) u_cap (
    .clk(clk), .rst(rst), .rise_i(rise), .ws_i(ws_s), .dat_i(dat_s),
    .fmt_i(fmt_i), .word_o(word), .chan_o(word_chan), .word_vld_o(word_vld)
  );

  sa_frame_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk(clk), .rst(rst), .word_i(word), .chan_i(word_chan), .vld_i(word_vld),
    .left_o(left_o), .right_o(right_o), .frame_valid_o(frame_valid_o)
  );
endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCK   = 4;
  localparam int NV         = 9;

  localparam logic [2:0]  T_FMT  [NV] = '{3'b000, 3'b000, 3'b100, 3'b100, 3'b001,
                                          3'b010, 3'b011, 3'b011, 3'b101};
  localparam int          T_W    [NV] = '{20, 24, 20, 16, 16, 18, 20, 20, 20};
  localparam int          T_SLOT [NV] = '{32, 32, 32, 24, 32, 32, 24, 32, 32};
  localparam logic [31:0] T_L    [NV] = '{32'h81234, 32'hABCDEF, 32'hFFFFF, 32'h8001,
                                          32'hC3A5, 32'h2AAAA, 32'h80000, 32'h13579, 32'h5A5A5};
  localparam logic [31:0] T_R    [NV] = '{32'h7EDCB, 32'h123456, 32'h00001, 32'h7FFE,
                                          32'h5A3C, 32'h15555, 32'h0FFFF, 32'h2468A, 32'hA5A5A};
  localparam string       T_TAG  [NV] = '{"R2", "R2", "R3", "R3", "R4", "R4", "R9", "R4", "R7"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic [19:0] left_o, right_o;
  logic        frame_valid_o;

  int errors = 0, checks = 0, exp_n = 0, rx_n = 0;
  logic [19:0] exp_l [32];
  logic [19:0] exp_r [32];
  string       exp_tag [32];

  serial_audio_rx uut (
    .clk(clk), .rst(rst), .bck_i(bck), .ws_i(ws), .sdata_i(sd), .fmt_i(fmt),
    .left_o(left_o), .right_o(right_o), .frame_valid_o(frame_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int fmt_len(input logic [2:0] f, input int w);
    case (f)
      3'b001:  return 16;
      3'b010:  return 18;
      3'b011:  return 20;
      default: return w;
    endcase
  endfunction

  function automatic logic [19:0] expect_word(input logic [2:0] f, input int w, input logic [31:0] word);
    int n = fmt_len(f, w);
    logic [31:0] m = word & ((32'h1 << n) - 32'h1);
    if (n <= 20) return m[19:0] << (20 - n);
    return 20'(m >> (n - 20));
  endfunction

  function automatic logic slot_bit(input logic [2:0] f, input int w, input logic [31:0] word,
                                    input int slot, input int p);
    int n = fmt_len(f, w);
    if (f == 3'b001 || f == 3'b010 || f == 3'b011)
      return (p >= slot - n) ? word[n - 1 - (p - (slot - n))] : 1'b1;
    if (f == 3'b100) begin
      if (p < w) return word[w - 1 - p];
      return p >= 20;
    end
    if (p == 0) return 1'b1;
    if (p <= w) return word[w - p];
    return p > 20;
  endfunction

  task automatic send_bit(input logic w_s, input logic d);
    @(negedge clk);
    bck = 1'b0; ws = w_s; sd = d;
    repeat (HALF_BCK) @(negedge clk);
    bck = 1'b1;
    repeat (HALF_BCK - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [2:0] f_drive, input logic [2:0] f_late,
                            input logic [2:0] f_enc, input int w, input int slot,
                            input logic [31:0] lw, input logic [31:0] rw);
    fmt = f_drive;
    for (int p = 0; p < slot; p++) begin
      send_bit(1'b0, slot_bit(f_enc, w, lw, slot, p));
      if (p == 0) fmt = f_late;
    end
    for (int p = 0; p < slot; p++) send_bit(1'b1, slot_bit(f_enc, w, rw, slot, p));
  endtask

  task automatic expect_frame(input logic [2:0] f, input int w, input logic [31:0] lw,
                              input logic [31:0] rw, input string tag);
    exp_l[exp_n]   = expect_word(f, w, lw);
    exp_r[exp_n]   = expect_word(f, w, rw);
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic go_idle();
    @(negedge clk);
    bck = 1'b0; ws = 1'b0; sd = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // Monitor: each pulse is compared with the next expected pair (R5 channel order).
  always @(negedge clk) begin
    if (!rst && frame_valid_o) begin
      if (rx_n < exp_n) begin
        chk({exp_tag[rx_n], "/R5 left"},  left_o,  exp_l[rx_n]);
        chk({exp_tag[rx_n], "/R5 right"}, right_o, exp_r[rx_n]);
      end else begin
        chk("R8 unexpected pulse", 20'(rx_n), 20'(exp_n));
      end
      rx_n++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs clear during reset
    chk("R1 left",  left_o, 20'h0);
    chk("R1 right", right_o, 20'h0);
    chk("R1 valid", {19'h0, frame_valid_o}, 20'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after release", {19'h0, frame_valid_o}, 20'h0);

    // R8: priming frame is discarded
    send_frame(3'b000, 3'b000, 3'b000, 20, 32, 32'h11111, 32'h22222);
    for (int v = 0; v < NV; v++) begin
      expect_frame(T_FMT[v], T_W[v], T_L[v], T_R[v], T_TAG[v]);
      send_frame(T_FMT[v], T_FMT[v], T_FMT[v], T_W[v], T_SLOT[v], T_L[v], T_R[v]);
    end
    // R6: code switched to LSB16 after the left slot has started; frame stays MSB-justified
    expect_frame(3'b100, 20, 32'hC0FFE, 32'h3BEEF, "R6");
    send_frame(3'b100, 3'b001, 3'b100, 20, 32, 32'hC0FFE, 32'h3BEEF);
    // flush frame closes the previous one
    send_frame(3'b000, 3'b000, 3'b000, 20, 32, 32'h0, 32'h0);
    go_idle();
    chk("R5 pulse count", 20'(rx_n), 20'(exp_n));
    chk("R5 hold left",  left_o,  20'hC0FFE);
    chk("R5 hold right", right_o, 20'h3BEEF);

    // Reset in the middle of the stream
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 left after reset",  left_o,  20'h0);
    chk("R1 right after reset", right_o, 20'h0);

    // R8: first frame after reset produces no pulse; the second one does
    send_frame(3'b010, 3'b010, 3'b010, 18, 32, 32'h3FFFF, 32'h3FFFF);
    chk("R8 no pulse for first frame", 20'(rx_n), 20'(exp_n));
    expect_frame(3'b010, 18, 32'h1F00F, 32'h20FF0, "R8");
    send_frame(3'b010, 3'b010, 3'b010, 18, 32, 32'h1F00F, 32'h20FF0);
    send_frame(3'b000, 3'b000, 3'b000, 20, 32, 32'h0, 32'h0);
    go_idle();
    chk("R8 pulse count", 20'(rx_n), 20'(exp_n));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule